// File: doc/BRIEF.md
# Urgency-Ordered Rule Firing Scheduler

This block decides, once per clock, which of a fixed set of guarded atomic actions may fire. Each requester presents an enable predicate that the surrounding logic has already evaluated from the current state. It also presents two masks over a small set of shared state elements: the elements it reads and the elements it writes. From the masks the block derives a symmetric pairwise conflict relation. It then walks the requesters from most to least urgent and grants each one whose predicate is true and which clashes with nothing already granted. The result is a maximal conflict-free set, not a single winner.

Requesters 0 and 1 are externally invoked methods and requesters 2 to 7 are internal rules. By default the methods outrank all rules. The `rules_first` input moves the whole rule group above the methods. Inside each group a lower index is more urgent. The grant vector is captured in a register, and the execution logic consumes it on the following cycle. All pins are plain control signals with no handshake: a new set of predicates is accepted on every clock and cannot be held off.

Top module: `rule_sched_top`

## Requirements
- R1: While `rst` is high at a rising edge, `fire_q` becomes 0 at that edge, whatever the other inputs are.
- R2: `fire_q` shows the grant computed from the inputs present at the previous rising edge. It holds its value between edges.
- R3: A requester whose bit in `enable_pred` is 0 is never granted, and it blocks no other requester.
- R4: Requesters i and j (i != j) conflict when they write a common state element, or when one reads an element the other writes. Bit k of `read_set[i*8 +: 8]` or `write_set[i*8 +: 8]` means that requester i reads or writes element k. Sharing only reads is not a conflict.
- R5: No two conflicting requesters are granted in the same cycle.
- R6: Requesters are visited in descending urgency. A requester is granted only if it conflicts with no requester that has already been granted. A requester that conflicts only with blocked requesters is still granted.
- R7: With `rules_first`=0 the urgency order is 0,1,2,...,7, so the methods come before the rules.
- R8: With `rules_first`=1 the urgency order is 2,3,...,7,0,1, so the rules come before the methods.
- R9: All predicates low gives `fire_q`=8'h00. All predicates high with no conflicts gives 8'hFF.
- R10: A requester that reads and writes the same element is not in conflict with itself, because the diagonal of the conflict relation is ignored.
- R11: The grant is maximal. Every requester that is enabled but not granted conflicts with at least one granted requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rules_first | input | 1 | 1 places the rule group above the method group in urgency |
| enable_pred | input | 8 | Enable predicate per requester |
| read_set | input | 64 | Read mask per requester, 8 bits each, requester i at bits i*8+7..i*8 |
| write_set | input | 64 | Write mask per requester, same layout as read_set |
| fire_q | output | 8 | Registered grant vector, one bit per requester |

## Verification
The hardest situation to reach is a requester that conflicts with a more urgent requester that has itself been blocked. A plain priority chain would wrongly suppress it. The stimulus builds a three-link chain over shared write elements, so the middle requester is blocked and the two ends must both be granted. A second group of scenarios checks each group-order reversal by placing a method and a rule on the same written element, with `rules_first` at 0 and then at 1.

// File: rtl/rule_sched_pkg.sv
package rule_sched_pkg;
  localparam int unsigned REQ_COUNT    = 8;
  localparam int unsigned METHOD_COUNT = 2;
  localparam int unsigned ELEM_COUNT   = 8;
endpackage

// File: rtl/sched_conflicts.sv
module sched_conflicts #(
  parameter int unsigned N = 8,
  parameter int unsigned S = 8
) (
  input  logic [N*S-1:0]        read_set,
  input  logic [N*S-1:0]        write_set,
  output logic [N-1:0][N-1:0]   conf
);
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign conf[i][j] = 1'b0;
      end else begin : g_pair
        logic [S-1:0] ww, rw, wr;
        assign ww = write_set[i*S +: S] & write_set[j*S +: S];
        assign rw = read_set[i*S +: S]  & write_set[j*S +: S];
        assign wr = write_set[i*S +: S] & read_set[j*S +: S];
        assign conf[i][j] = |(ww | rw | wr);
      end
    end
  end
endmodule

// File: rtl/sched_order.sv
module sched_order #(
  parameter int unsigned N  = 8,
  parameter int unsigned NM = 2,
  parameter int unsigned IW = 3
) (
  input  logic                  rules_first,
  output logic [N-1:0][IW-1:0]  order
);
  localparam int unsigned NR = N - NM;
  for (genvar p = 0; p < N; p++) begin : g_slot
    localparam int unsigned RF_IDX = (p < NR) ? (p + NM) : (p - NR);
    assign order[p] = rules_first ? IW'(RF_IDX) : IW'(p);
  end
endmodule

// File: rtl/sched_greedy.sv
module sched_greedy #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          enable_pred,
  input  logic [N-1:0][N-1:0]   conf,
  input  logic [N-1:0][IW-1:0]  order,
  output logic [N-1:0]          grant
);
  always_comb begin
    logic [N-1:0] taken;
    logic [IW-1:0] idx;
    taken = '0;
    for (int p = 0; p < N; p++) begin
      idx = order[p];
      if (enable_pred[idx] && !(|(conf[idx] & taken)))
        taken[idx] = 1'b1;
    end
    grant = taken;
  end

  logic clash, missed, lead_ok;
  always_comb begin
    clash  = 1'b0;
    missed = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++)
        if (grant[i] && grant[j] && conf[i][j]) clash = 1'b1;
      if (enable_pred[i] && !grant[i] && !(|(conf[i] & grant))) missed = 1'b1;
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    lead_ok = 1'b1;
    for (int p = 0; p < N; p++) begin
      if (!found && enable_pred[order[p]]) begin
        found   = 1'b1;
        lead_ok = grant[order[p]];
      end
    end
  end

  // R3
  grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~enable_pred) == '0);
  // R5
  no_clash_chk: assert property (@(posedge clk) disable iff (rst) !clash);
  // R11
  maximal_chk: assert property (@(posedge clk) disable iff (rst) !missed);
  // R6
  lead_granted_chk: assert property (@(posedge clk) disable iff (rst) lead_ok);
endmodule

// File: rtl/rule_sched_top.sv
module rule_sched_top
  import rule_sched_pkg::*;
#(
  parameter int unsigned N  = REQ_COUNT,
  parameter int unsigned NM = METHOD_COUNT,
  parameter int unsigned S  = ELEM_COUNT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rules_first,
  input  logic [N-1:0]    enable_pred,
  input  logic [N*S-1:0]  read_set,
  input  logic [N*S-1:0]  write_set,
  output logic [N-1:0]    fire_q
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][N-1:0]  conf;
  logic [N-1:0][IW-1:0] order;
  logic [N-1:0]         grant;

  sched_conflicts #(.N(N), .S(S)) u_conf (
    .read_set(read_set), .write_set(write_set), .conf(conf));

  sched_order #(.N(N), .NM(NM), .IW(IW)) u_order (
    .rules_first(rules_first), .order(order));

  sched_greedy #(.N(N), .IW(IW)) u_pick (
    .clk(clk), .rst(rst), .enable_pred(enable_pred),
    .conf(conf), .order(order), .grant(grant));

  always_ff @(posedge clk) begin
    if (rst) fire_q <= '0;
    else     fire_q <= grant;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> fire_q == '0);
  // R3
  fire_subset_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (fire_q & ~$past(enable_pred)) == '0);
endmodule

// File: tb/rule_sched_top_tb.sv
`timescale 1ns/1ps
module rule_sched_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rules_first = 1'b0;
  logic [7:0]  enable_pred = '0;
  logic [63:0] read_set = '0;
  logic [63:0] write_set = '0;
  logic [7:0]  fire_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rule_sched_top dut_i (
    .clk(clk), .rst(rst), .rules_first(rules_first),
    .enable_pred(enable_pred), .read_set(read_set),
    .write_set(write_set), .fire_q(fire_q));

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (fire_q !== exp) begin
      fails++;
      $display("FAIL %s: fire_q=%h expected=%h", req, fire_q, exp);
    end
  endtask

  task automatic clear_masks();
    read_set = '0; write_set = '0;
  endtask

  task automatic set_rd(input int r, input int e);
    read_set[r*8 + e] = 1'b1;
  endtask

  task automatic set_wr(input int r, input int e);
    write_set[r*8 + e] = 1'b1;
  endtask

  // drive at negedge, cross one posedge, sample at the next negedge
  task automatic step(input logic [7:0] pred, input logic rf);
    @(negedge clk);
    enable_pred = pred; rules_first = rf;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_masks();
    rst = 1'b1;
    step(8'hFF, 1'b0);
    check("R1 reset", 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_none_all();
    clear_masks();
    step(8'h00, 1'b0);
    check("R9 none", 8'h00);
    for (int r = 0; r < 8; r++) set_wr(r, r);
    step(8'hFF, 1'b0);
    check("R9 all", 8'hFF);
    step(8'hFF, 1'b1);
    check("R9 all rules_first", 8'hFF);
  endtask

  task automatic t_latency();
    clear_masks();
    step(8'hA5, 1'b0);
    check("R2 capture", 8'hA5);
    enable_pred = 8'h00;
    #1;
    check("R2 hold between edges", 8'hA5);
    @(posedge clk);
    @(negedge clk);
    check("R2 next edge", 8'h00);
  endtask

  task automatic t_rules_r4();
    clear_masks();
    set_rd(2, 5); set_rd(3, 5); set_wr(2, 0); set_wr(3, 1);
    step(8'h0C, 1'b0);
    check("R4 shared read", 8'h0C);
    clear_masks();
    set_wr(2, 4); set_wr(3, 4);
    step(8'h0C, 1'b0);
    check("R5 write-write", 8'h04);
    clear_masks();
    set_rd(3, 6); set_wr(5, 6);
    step(8'h28, 1'b0);
    check("R4 read vs write", 8'h08);
    clear_masks();
    set_wr(3, 6); set_rd(5, 6);
    step(8'h28, 1'b0);
    check("R4 write vs read", 8'h08);
  endtask

  task automatic t_order();
    clear_masks();
    set_wr(0, 2); set_wr(4, 2);
    step(8'h11, 1'b0);
    check("R7 method over rule", 8'h01);
    step(8'h11, 1'b1);
    check("R8 rule over method", 8'h10);
    clear_masks();
    set_wr(1, 3); set_wr(7, 3);
    step(8'h82, 1'b1);
    check("R8 last rule over method", 8'h80);
    clear_masks();
    set_wr(0, 1); set_wr(1, 1);
    step(8'h03, 1'b1);
    check("R8 methods ascending", 8'h01);
    clear_masks();
    set_wr(5, 0); set_wr(6, 0);
    step(8'h60, 1'b0);
    check("R7 rules ascending", 8'h20);
  endtask

  task automatic t_chain();
    clear_masks();
    set_wr(2, 0); set_wr(3, 0); set_wr(3, 1); set_wr(4, 1);
    step(8'h1C, 1'b0);
    check("R6 R11 chain", 8'h14);
    step(8'h18, 1'b0);
    check("R6 chain head idle", 8'h08);
  endtask

  task automatic t_disabled();
    clear_masks();
    set_wr(0, 0); set_wr(1, 0);
    step(8'h02, 1'b0);
    check("R3 idle does not block", 8'h02);
  endtask

  task automatic t_diag();
    clear_masks();
    set_rd(6, 3); set_wr(6, 3);
    step(8'h40, 1'b0);
    check("R10 self read-write", 8'h40);
  endtask

  initial begin
    t_reset();
    t_none_all();
    t_latency();
    t_rules_r4();
    t_order();
    t_chain();
    t_disabled();
    t_diag();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule